// File: doc/BRIEF.md
# Prioritized interrupt vector selector

This block picks which interrupt to service when a vector-select instruction runs. On a start strobe it samples a 16-bit pending vector, a 16-bit enable vector and the address of the executing instruction. It ranks the qualifying sources and finds the winner's two-byte entry in a jump table. It then fetches the entry over a synchronous byte-read port, high byte first, and presents the 16-bit jump target and the winning rank for one cycle.

Bit i of the pending and enable vectors belongs to rank index i. Index 0 is the highest priority. The table page comes from the executing instruction's own address. Entries run downward from the top of that page, one pair of bytes per rank. If nothing qualifies, the lowest-ranked default entry is used. This is not treated as an error.

Top module: `vec_sel`

## Requirements
- R1: A source at index i (2..6, 8..14) qualifies only when both `pend[i]` and `en[i]` are 1. Among the qualifying sources, the lowest index wins and is reported on `rank`.
- R2: Index 0 (software trap) qualifies on `pend[0]` alone, whatever `en[0]` holds, and it outranks every other index.
- R3: Indices 1 and 7 are reserved and never win, whatever their input bits.
- R4: Index 15 has no source. When no index qualifies, `rank` is 15 and the entry at page offsets E0/E1 is fetched, with no stall.
- R5: For winning index r, the high byte is read from page offset FE−2r and the low byte from offset FF−2r.
- R6: The table page is `pc[15:8]`. When `pc[7:0]` is FF, the page is `pc[15:8]+1` instead, and page FF wraps to 00.
- R7: `pend`, `en` and `pc` are sampled only on the cycle `start` is accepted. Later changes do not alter the lookup.
- R8: After the accepting edge, the high-byte read is issued in the next cycle and the low-byte read in the cycle after that. `mem_data` carries the byte one cycle after its read. `done` is high for exactly one cycle, the third after acceptance, with `target` = {high byte, low byte}.
- R9: `start` is accepted only when no lookup is in progress. A request during a lookup causes no extra memory reads and no extra `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request a vector lookup |
| pend | input | 16 | Pending flags, bit i = rank index i |
| en | input | 16 | Enable flags, bit i = rank index i |
| pc | input | 16 | Address of the selecting instruction |
| mem_rd | output | 1 | Byte read strobe |
| mem_addr | output | 16 | Byte read address |
| mem_data | input | 8 | Read data, valid the cycle after `mem_rd` |
| done | output | 1 | One-cycle result strobe |
| target | output | 16 | Fetched jump target |
| rank | output | 4 | Winning rank index 0..15 |

## Verification
The bench builds the block with its default 16-bit address and 16 ranks. This small size lets it apply every single-bit pending pattern, both with all enables set and with all enables clear. It also applies every pair of pending bits, which covers each precedence relation, including the reserved and trap indices. Several instruction addresses stress the page rule, including a page's last byte and the wrap from the top of memory. Lookups that change the inputs, or raise `start` again mid-flight, cover the sampling and busy rules.

// File: rtl/vec_sel.sv
module vec_sel #(
  parameter int PC_W = 16,
  parameter int NSRC = 16,
  parameter logic [NSRC-1:0] RSVD = 16'h0082
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [NSRC-1:0] pend,
  input  logic [NSRC-1:0] en,
  input  logic [PC_W-1:0] pc,
  output logic            mem_rd,
  output logic [PC_W-1:0] mem_addr,
  input  logic [7:0]      mem_data,
  output logic            done,
  output logic [15:0]     target,
  output logic [3:0]      rank
);
  localparam int RW = $clog2(NSRC);
  localparam int PW = PC_W - 8;

  typedef enum logic [1:0] {S_IDLE, S_HI, S_LO, S_DONE} st_t;
  st_t st;

  logic [NSRC-1:0] qual;
  logic [RW-1:0]   win, rank_q;
  logic [PW-1:0]   page_q;
  logic [7:0]      hi_q, off;

  assign qual = pend & (en | NSRC'(1)) & ~RSVD & ~(NSRC'(1) << (NSRC-1));

  always_comb begin
    win = RW'(NSRC-1);
    for (int i = NSRC-2; i >= 0; i--)
      if (qual[i]) win = RW'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      rank_q <= '0;
      page_q <= '0;
      hi_q   <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st     <= S_HI;
          rank_q <= win;
          page_q <= pc[PC_W-1:8] + PW'(pc[7:0] == 8'hFF);
        end
        S_HI:   st <= S_LO;
        S_LO:   begin st <= S_DONE; hi_q <= mem_data; end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign off      = 8'hFE - 8'({rank_q, 1'b0});
  assign mem_rd   = (st == S_HI) || (st == S_LO);
  assign mem_addr = {page_q, off[7:1], st == S_LO};
  assign done     = st == S_DONE;
  assign target   = {hi_q, mem_data};
  assign rank     = 4'(rank_q);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R5
  pair_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !mem_addr[0]) |=> (mem_rd && mem_addr[0] && mem_addr[PC_W-1:1] == $past(mem_addr[PC_W-1:1])));
  // R5
  table_region_chk: assert property (@(posedge clk) disable iff (!rst_n) mem_rd |-> mem_addr[7:5] == 3'b111);
  // R3
  no_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> (rank != 4'd1 && rank != 4'd7));
  // R5
  rank_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(mem_addr[7:0]) == 8'hFF - 8'({rank, 1'b0}));
  // R9
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !mem_rd);
endmodule

// File: tb/vec_sel_bench.sv
module vec_sel_bench;
  localparam int CLK_PER = 10;

  logic clk = 0, rst_n = 0, start = 0;
  logic [15:0] pend = 0, en = 0, pc = 0;
  logic mem_rd, done;
  logic [15:0] mem_addr, target;
  logic [7:0] mem_data = 0;
  logic [3:0] rank;
  logic [15:0] hi_a = 0, lo_a = 0;
  int rd_cnt = 0, nchk = 0, nbad = 0, cyc = 0;

  always #(CLK_PER/2) clk = ~clk;

  vec_sel u_vec_sel (.clk, .rst_n, .start, .pend, .en, .pc, .mem_rd, .mem_addr,
                     .mem_data, .done, .target, .rank);

  function automatic logic [7:0] fmem(logic [15:0] a);
    return a[15:8] ^ (a[7:0] * 8'd7) ^ 8'h5A;
  endfunction

  always @(posedge clk) if (mem_rd) begin
    mem_data <= fmem(mem_addr);
    if (mem_addr[0]) lo_a <= mem_addr; else hi_a <= mem_addr;
    rd_cnt <= rd_cnt + 1;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      nbad++;
      $display("FAIL watchdog: act=%0d exp<=150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] ref_rank(logic [15:0] p, logic [15:0] e);
    if (p[0]) return 4'd0;
    for (int i = 2; i < 15; i++)
      if (i != 7 && p[i] && e[i]) return 4'(i);
    return 4'd15;
  endfunction

  task automatic lookup(logic [15:0] p, logic [15:0] e, logic [15:0] a, bit poke);
    logic [3:0] er;
    logic [7:0] pg, ofs;
    int rc;
    er  = ref_rank(p, e);
    pg  = a[15:8] + 8'(a[7:0] == 8'hFF);
    ofs = 8'hFE - 8'(2 * er);
    @(negedge clk);
    pend = p; en = e; pc = a; start = 1;
    rc = rd_cnt;
    @(negedge clk);
    start = poke;
    if (poke) begin pend = ~p; en = ~e; pc = a ^ 16'h1234; end
    chk("R8 hi read issued", {31'd0, mem_rd}, 1);
    @(negedge clk);
    start = 0;
    @(negedge clk);
    chk("R8 done", {31'd0, done}, 1);
    chk("R1 R2 R3 R4 R7 rank", {28'd0, rank}, {28'd0, er});
    chk("R5 R6 hi addr", {16'd0, hi_a}, {16'd0, pg, ofs});
    chk("R5 R6 lo addr", {16'd0, lo_a}, {16'd0, pg, ofs | 8'h01});
    chk("R8 target", {16'd0, target}, {16'd0, fmem({pg, ofs}), fmem({pg, ofs | 8'h01})});
    @(negedge clk);
    chk("R8 done one cycle", {31'd0, done}, 0);
    @(negedge clk);
    chk("R9 read count", rd_cnt - rc, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("reset done", {31'd0, done}, 0);
    chk("reset rd", {31'd0, mem_rd}, 0);
    rst_n = 1;
    for (int i = 0; i < 16; i++) begin
      lookup(16'(1) << i, 16'hFFFF, 16'h3A10, 0);
      lookup(16'(1) << i, 16'h0000, 16'h3A10, 0);
    end
    for (int i = 0; i < 16; i++)
      for (int j = i + 1; j < 16; j++)
        lookup((16'(1) << i) | (16'(1) << j), 16'hFFFF, 16'h0500 + 16'(i), 0);
    lookup(16'h0000, 16'hFFFF, 16'h12FF, 0);   // R4 R6
    lookup(16'h0010, 16'hFFFF, 16'hFFFF, 0);   // R6 wrap
    lookup(16'h4000, 16'hFFFF, 16'h00FE, 0);   // R6
    lookup(16'h0082, 16'hFFFF, 16'h7700, 0);   // R3
    lookup(16'h0001, 16'h0000, 16'hC0FF, 0);   // R2
    lookup(16'h0300, 16'h0200, 16'h2345, 1);   // R7 R9
    lookup(16'h0000, 16'h0000, 16'h8080, 1);   // R7 R9
    lookup(16'h6004, 16'h4000, 16'hAAFF, 1);   // R7 R9
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule